// File: doc/BRIEF.md
# Snooping Write-Invalidate Coherence Controller

This controller sits beside one write-back cache in a bus-based multiprocessor and keeps a small direct-mapped tag and state array coherent. Each line is Invalid, Shared (clean and agrees with memory, so other caches may also hold it) or Exclusive (dirty, and this cache holds the only copy). A cache that wants to write must first own the line exclusively. Writes therefore invalidate every other copy.

The controller takes local processor requests, each a read or a write to one address. It decides whether the request is a quiet hit or needs the shared bus. When it needs the bus, it raises a bus request and places a command and address on its outputs. The transaction counts as issued in the cycle the arbiter grants it. The controller also watches transactions that other caches put on the bus. It answers them in the same cycle: it supplies data, aborts the memory response or writes back, and it downgrades or invalidates its own line to match.

Only one controller owns the bus in a given cycle. A controller that loses arbitration keeps requesting. After each snooped transaction it re-derives its command from the updated line state.

Top module: `coh_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid, and bus_req, bus_lock, req_ready, snp_supply, snp_abort and snp_wb are all low.
- R2: A read whose line is Invalid or holds another clean tag raises bus_req with bus_cmd=1 (read) and bus_addr equal to req_addr. On grant, req_ready pulses and the line becomes Shared with the new tag.
- R3: A write whose line is Invalid or holds another clean tag raises bus_req with bus_cmd=2 (read-and-invalidate). On grant, req_ready pulses and the line becomes Exclusive.
- R4: A read hit on a Shared line completes in the same cycle with bus_req low. A write hit on a Shared line issues bus_cmd=2 and leaves the line Exclusive after the grant.
- R5: A read or write hit on an Exclusive line completes in the same cycle, and bus_req stays low.
- R6: A miss whose line holds a different Exclusive tag first issues bus_cmd=3 (write-back) with bus_addr = {old tag, index}. After that grant, bus_lock stays high and the controller issues the read (for a read) or the read-and-invalidate (for a write). The new line then ends Shared or Exclusive accordingly.
- R7: A snooped read (snp_cmd=1) that hits an Exclusive line raises snp_supply and snp_abort in that cycle, and the line becomes Shared.
- R8: A snooped read-and-invalidate (snp_cmd=2) that hits an Exclusive line raises snp_wb and snp_abort, and the line becomes Invalid. On a Shared line the line becomes Invalid with no output. Any other snoop gives no output and changes nothing. The address is split as index = addr[IDX_W-1:0] and tag = the remaining upper bits.
- R9: A snoop takes priority over a local request in the same cycle. req_ready is held low in that cycle, and the local request is re-evaluated against the updated state. For example, a pending write-back whose victim a snoop has just invalidated turns straight into the fill command.
- R10: While grant is absent, bus_req stays high, bus_cmd and bus_addr stay steady, and req_ready stays low. A request that needs the bus completes only in a granted cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Local request present, held until req_ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Local request address |
| req_ready | output | 1 | Local request completes this cycle |
| bus_req | output | 1 | Bus arbitration request |
| bus_lock | output | 1 | Bus held between write-back and fill |
| bus_gnt | input | 1 | Bus granted this cycle |
| bus_cmd | output | 2 | 0 none, 1 read, 2 read-and-invalidate, 3 write-back |
| bus_addr | output | ADDR_W | Address of the issued transaction |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_cmd | input | 2 | Snooped command, same encoding as bus_cmd |
| snp_addr | input | ADDR_W | Snooped address |
| snp_supply | output | 1 | This cache drives the line data |
| snp_abort | output | 1 | Abort the memory response |
| snp_wb | output | 1 | This cache writes the dirty line back |

## Verification
Several properties are checked on every cycle. Snoop responses never pair a supply with a write-back, and a supply always comes with an abort. A snoop cycle never completes a local request, and the snoop and local paths never write the array together. A granted write-back is always followed by a held bus whose next command is a fill. A stalled request keeps its command steady. The actual state transitions can only be shown by the bench's scenarios, because they are visible only through later hits, misses and snoop answers. The bench sweeps every index, start state, access type and tag relation, with several grant delays, and it runs the directed case where a snoop cancels a pending write-back.

// File: rtl/coh_pkg.sv
package coh_pkg;

  typedef enum logic [1:0] {
    LN_INV = 2'd0,
    LN_SHR = 2'd1,
    LN_EXC = 2'd2
  } line_st_t;

  typedef enum logic [1:0] {
    BC_NONE = 2'd0,
    BC_RD   = 2'd1,
    BC_RDX  = 2'd2,
    BC_WB   = 2'd3
  } bus_cmd_t;

  // Local access that needs no bus traffic at all.
  function automatic logic quiet_hit(line_st_t st, logic tag_eq, logic wr);
    return tag_eq && ((st == LN_EXC) || ((st == LN_SHR) && !wr));
  endfunction

  // The indexed line holds a different, dirty block that must leave first.
  function automatic logic dirty_victim(line_st_t st, logic tag_eq);
    return !tag_eq && (st == LN_EXC);
  endfunction

  function automatic bus_cmd_t fill_cmd(logic wr);
    return wr ? BC_RDX : BC_RD;
  endfunction

  function automatic line_st_t fill_state(logic wr);
    return wr ? LN_EXC : LN_SHR;
  endfunction

  // State of a matching line after another cache's transaction.
  function automatic line_st_t snoop_next(line_st_t st, bus_cmd_t cmd);
    line_st_t nx;
    nx = st;
    if (cmd == BC_RD && st == LN_EXC) nx = LN_SHR;
    else if (cmd == BC_RDX)           nx = LN_INV;
    return nx;
  endfunction

endpackage

// File: rtl/coh_tag_array.sv
module coh_tag_array import coh_pkg::*; #(
  parameter int IDX_W = 2,
  parameter int TAG_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] a_idx,
  output logic [TAG_W-1:0] a_tag,
  output line_st_t         a_st,
  input  logic [IDX_W-1:0] b_idx,
  output logic [TAG_W-1:0] b_tag,
  output line_st_t         b_st,
  input  logic             loc_we,
  input  logic [IDX_W-1:0] loc_idx,
  input  logic [TAG_W-1:0] loc_tag,
  input  line_st_t         loc_st,
  input  logic             snp_we,
  input  logic [IDX_W-1:0] snp_idx,
  input  line_st_t         snp_st
);
  localparam int LINES = 1 << IDX_W;

  logic [TAG_W-1:0] tag_q [LINES];
  line_st_t         st_q  [LINES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) begin
        tag_q[i] <= '0;
        st_q[i]  <= LN_INV;
      end
    end else begin
      if (loc_we) begin
        tag_q[loc_idx] <= loc_tag;
        st_q[loc_idx]  <= loc_st;
      end
      if (snp_we) st_q[snp_idx] <= snp_st;
    end
  end

  assign a_tag = tag_q[a_idx];
  assign a_st  = st_q[a_idx];
  assign b_tag = tag_q[b_idx];
  assign b_st  = st_q[b_idx];

  AST_ONE_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
    !(loc_we && snp_we)); // R9

endmodule

// File: rtl/coh_snoop_unit.sv
module coh_snoop_unit import coh_pkg::*; #(
  parameter int TAG_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             snp_valid,
  input  bus_cmd_t         snp_cmd,
  input  logic [TAG_W-1:0] snp_tag,
  input  logic [TAG_W-1:0] line_tag,
  input  line_st_t         line_st,
  output logic             supply,
  output logic             abort_mem,
  output logic             wr_back,
  output logic             upd_we,
  output line_st_t         upd_st
);
  logic snp_match;
  logic was_dirty;

  assign snp_match = snp_valid && (line_st != LN_INV) && (line_tag == snp_tag);
  assign was_dirty = snp_match && (line_st == LN_EXC);

  assign supply    = was_dirty && (snp_cmd == BC_RD);
  assign wr_back   = was_dirty && (snp_cmd == BC_RDX);
  assign abort_mem = supply || wr_back;

  assign upd_st = snoop_next(line_st, snp_cmd);
  assign upd_we = snp_match && (upd_st != line_st);

  AST_SUPPLY_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
    supply |-> abort_mem); // R7
  AST_SNOOP_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({supply, wr_back})); // R8
  AST_SNOOP_OUT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (supply || abort_mem || wr_back || upd_we) |-> snp_valid); // R8

endmodule

// File: rtl/coh_req_unit.sv
module coh_req_unit import coh_pkg::*; #(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [ADDR_W-IDX_W-1:0] line_tag,
  input  line_st_t          line_st,
  input  logic              snp_valid,
  input  logic              bus_gnt,
  output logic              req_ready,
  output logic              bus_req,
  output logic              bus_lock,
  output bus_cmd_t          bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              loc_we,
  output logic [IDX_W-1:0]  loc_idx,
  output logic [ADDR_W-IDX_W-1:0] loc_tag,
  output line_st_t          loc_st
);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0] req_idx;
  logic [TAG_W-1:0] req_tag;
  logic tag_eq, quiet, dirty, need_bus, granted;
  logic wb_step, fill_step;
  logic hold_q;

  assign req_idx = req_addr[IDX_W-1:0];
  assign req_tag = req_addr[ADDR_W-1:IDX_W];
  assign tag_eq  = (line_tag == req_tag);
  assign quiet   = quiet_hit(line_st, tag_eq, req_write);
  assign dirty   = dirty_victim(line_st, tag_eq);

  // Plan is recomputed every cycle from the live line state, so a
  // snoop that changed the line simply yields a different command.
  assign need_bus = req_valid && !quiet;
  assign bus_req  = need_bus;
  assign bus_cmd  = !need_bus ? BC_NONE : (dirty ? BC_WB : fill_cmd(req_write));
  assign bus_addr = dirty ? {line_tag, req_idx} : req_addr;

  assign granted   = need_bus && bus_gnt && !snp_valid;
  assign wb_step   = granted && dirty;
  assign fill_step = granted && !dirty;

  assign req_ready = req_valid && !snp_valid && (quiet || fill_step);

  assign loc_we  = wb_step || fill_step;
  assign loc_idx = req_idx;
  assign loc_tag = wb_step ? line_tag : req_tag;
  assign loc_st  = wb_step ? LN_INV : fill_state(req_write);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       hold_q <= 1'b0;
    else if (fill_step || !req_valid) hold_q <= 1'b0;
    else if (wb_step)                 hold_q <= 1'b1;
  end

  assign bus_lock = hold_q;

  AST_READY_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && bus_req) |-> bus_gnt); // R10
  AST_SNOOP_BLOCKS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |-> !req_ready); // R9
  AST_WB_HOLDS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_step && $stable(req_addr)) |=> (!req_valid || (bus_lock && bus_req))); // R6
  AST_LOCK_NEXT_IS_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_lock && bus_req) |-> (bus_cmd != BC_WB)); // R6
  AST_STALL_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt && !snp_valid) |=>
      (!req_valid || !$stable(req_addr) || !$stable(req_write) || $stable(bus_cmd))); // R10

endmodule

// File: rtl/coh_snoop_ctrl.sv
module coh_snoop_ctrl import coh_pkg::*; #(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              bus_req,
  output logic              bus_lock,
  input  logic              bus_gnt,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_supply,
  output logic              snp_abort,
  output logic              snp_wb
);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [TAG_W-1:0] a_tag, b_tag, loc_tag;
  line_st_t         a_st, b_st, loc_st, snp_st;
  logic             loc_we, snp_we;
  logic [IDX_W-1:0] loc_idx;
  bus_cmd_t         cmd_int;

  coh_tag_array #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_array (
    .clk(clk), .rst_n(rst_n),
    .a_idx(req_addr[IDX_W-1:0]), .a_tag(a_tag), .a_st(a_st),
    .b_idx(snp_addr[IDX_W-1:0]), .b_tag(b_tag), .b_st(b_st),
    .loc_we(loc_we), .loc_idx(loc_idx), .loc_tag(loc_tag), .loc_st(loc_st),
    .snp_we(snp_we), .snp_idx(snp_addr[IDX_W-1:0]), .snp_st(snp_st)
  );

  coh_snoop_unit #(.TAG_W(TAG_W)) u_snoop (
    .clk(clk), .rst_n(rst_n),
    .snp_valid(snp_valid), .snp_cmd(bus_cmd_t'(snp_cmd)),
    .snp_tag(snp_addr[ADDR_W-1:IDX_W]),
    .line_tag(b_tag), .line_st(b_st),
    .supply(snp_supply), .abort_mem(snp_abort), .wr_back(snp_wb),
    .upd_we(snp_we), .upd_st(snp_st)
  );

  coh_req_unit #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_req (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .line_tag(a_tag), .line_st(a_st),
    .snp_valid(snp_valid), .bus_gnt(bus_gnt),
    .req_ready(req_ready), .bus_req(bus_req), .bus_lock(bus_lock),
    .bus_cmd(cmd_int), .bus_addr(bus_addr),
    .loc_we(loc_we), .loc_idx(loc_idx), .loc_tag(loc_tag), .loc_st(loc_st)
  );

  assign bus_cmd = cmd_int;

endmodule

// File: tb/coh_snoop_ctrl_test.sv
module coh_snoop_ctrl_test;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [7:0] req_addr = '0;
  logic req_ready, bus_req, bus_lock;
  logic bus_gnt = 0;
  logic [1:0] bus_cmd;
  logic [7:0] bus_addr;
  logic snp_valid = 0;
  logic [1:0] snp_cmd = '0;
  logic [7:0] snp_addr = '0;
  logic snp_supply, snp_abort, snp_wb;

  int total = 0, bad = 0;
  bit finished = 0;
  int m_st [4];
  logic [5:0] m_tag [4];

  coh_snoop_ctrl uut (.*);

  always #(CLK_P/2) clk = ~clk;

  task automatic check(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic step();
    @(negedge clk); #1;
  endtask

  // Local access with grant delayed by dly cycles in each bus step.
  task automatic access(input logic [7:0] a, input bit wr, input int dly);
    logic [1:0] ix; logic [5:0] tg; bit quiet; string rq;
    ix = a[1:0]; tg = a[7:2];
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; bus_gnt = 0; #1;
    quiet = (m_tag[ix] == tg) && (m_st[ix] == 2 || (m_st[ix] == 1 && !wr));
    if (quiet) begin
      rq = (m_st[ix] == 2) ? "R5" : "R4";
      check(rq, "hit ready", req_ready, 1);
      check(rq, "hit bus_req", bus_req, 0);
    end else begin
      if (m_st[ix] == 2 && m_tag[ix] != tg) begin
        for (int d = 0; d < dly; d++) begin
          check("R10", "wb wait ready", req_ready, 0);
          check("R10", "wb wait cmd", bus_cmd, 3);
          step();
        end
        check("R6", "wb cmd", bus_cmd, 3);
        check("R6", "wb addr", bus_addr, {m_tag[ix], ix});
        check("R6", "wb bus_req", bus_req, 1);
        bus_gnt = 1; #1;
        check("R6", "wb no ready", req_ready, 0);
        @(posedge clk);
        m_st[ix] = 0;
        @(negedge clk); bus_gnt = 0; #1;
        check("R6", "lock after wb", bus_lock, 1);
      end
      if (m_tag[ix] == tg && m_st[ix] == 1) rq = "R4";
      else rq = wr ? "R3" : "R2";
      for (int d = 0; d < dly; d++) begin
        check("R10", "fill wait ready", req_ready, 0);
        check("R10", "fill wait req", bus_req, 1);
        step();
      end
      check(rq, "fill cmd", bus_cmd, wr ? 2 : 1);
      check(rq, "fill addr", bus_addr, a);
      bus_gnt = 1; #1;
      check(rq, "fill ready", req_ready, 1);
      @(posedge clk);
      m_tag[ix] = tg; m_st[ix] = wr ? 2 : 1;
    end
    @(negedge clk); req_valid = 0; bus_gnt = 0; #1;
    check("R6", "lock released", bus_lock, 0);
  endtask

  task automatic snoop(input logic [7:0] a, input logic [1:0] c);
    logic [1:0] ix; bit hit, e_sup, e_wb;
    ix = a[1:0];
    @(negedge clk);
    snp_valid = 1; snp_cmd = c; snp_addr = a; #1;
    hit = (m_st[ix] != 0) && (m_tag[ix] == a[7:2]);
    e_sup = hit && m_st[ix] == 2 && c == 1;
    e_wb  = hit && m_st[ix] == 2 && c == 2;
    check(e_sup ? "R7" : "R8", "supply", snp_supply, e_sup);
    check(e_wb ? "R8" : "R7", "wb", snp_wb, e_wb);
    check("R8", "abort", snp_abort, e_sup || e_wb);
    @(posedge clk);
    if (hit && c == 1 && m_st[ix] == 2) m_st[ix] = 1;
    else if (hit && c == 2) m_st[ix] = 0;
    @(negedge clk); snp_valid = 0;
  endtask

  task automatic set_state(input logic [7:0] a, input int st);
    logic [1:0] ix; ix = a[1:0];
    snoop({m_tag[ix], ix}, 2);
    if (st >= 1) access(a, 0, 0);
    if (st == 2) access(a, 1, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL R0 watchdog actual=1 expected=0");
    summary();
  end

  initial begin
    for (int i = 0; i < 4; i++) begin m_st[i] = 0; m_tag[i] = '0; end
    repeat (2) @(negedge clk);
    rst_n = 1; #1;
    // R1: quiet outputs after reset
    check("R1", "bus_req", bus_req, 0);
    check("R1", "bus_lock", bus_lock, 0);
    check("R1", "req_ready", req_ready, 0);
    check("R1", "snoop outs", {snp_supply, snp_abort, snp_wb}, 0);
    // R1: every index misses after reset, even for tag 0
    for (int i = 0; i < 4; i++) begin
      req_valid = 1; req_write = 0; req_addr = {6'd0, 2'(i)}; #1;
      check("R1", "miss after reset", {bus_req, req_ready}, 2'b10);
    end
    req_valid = 0;

    // R9: snoop in same cycle as a quiet hit holds ready low
    set_state({6'd5, 2'd2}, 2);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = {6'd5, 2'd2};
    snp_valid = 1; snp_cmd = 1; snp_addr = {6'd9, 2'd0}; #1;
    check("R9", "ready blocked by snoop", req_ready, 0);
    step(); snp_valid = 0; #1;
    check("R9", "ready after snoop", req_ready, 1);
    @(negedge clk); req_valid = 0;

    // R9: snoop invalidating a pending victim cancels the write-back
    set_state({6'd3, 2'd1}, 2);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = {6'd7, 2'd1}; #1;
    check("R6", "victim wb pending", bus_cmd, 3);
    step();
    snp_valid = 1; snp_cmd = 2; snp_addr = {6'd3, 2'd1}; #1;
    check("R9", "ready low in snoop", req_ready, 0);
    check("R9", "snoop wb", {snp_wb, snp_abort}, 2'b11);
    step(); snp_valid = 0; #1;
    check("R9", "cmd now fill", bus_cmd, 1);
    check("R9", "fill addr", bus_addr, {6'd7, 2'd1});
    check("R9", "no lock", bus_lock, 0);
    bus_gnt = 1; #1;
    check("R9", "fill ready", req_ready, 1);
    @(posedge clk);
    m_st[1] = 1; m_tag[1] = 6'd7;
    @(negedge clk); req_valid = 0; bus_gnt = 0;

    // Local sweep: index x start state x access type x tag relation
    for (int ix = 0; ix < 4; ix++)
      for (int st = 0; st < 3; st++)
        for (int wr = 0; wr < 2; wr++)
          for (int same = 0; same < 2; same++) begin
            logic [7:0] base;
            base = {6'(ix * 4 + st + 1), 2'(ix)};
            set_state(base, st);
            access(same ? base : {base[7:2] ^ 6'h15, base[1:0]}, wr[0], (ix + st + wr) % 3);
            access(base, 0, 0);
          end

    // Snoop sweep: index x start state x command x match, then probe
    for (int ix = 0; ix < 4; ix++)
      for (int st = 0; st < 3; st++)
        for (int c = 1; c < 4; c++)
          for (int mt = 0; mt < 2; mt++) begin
            logic [7:0] base;
            base = {6'(ix * 3 + c + 20), 2'(ix)};
            set_state(base, st);
            snoop(mt ? base : {base[7:2] ^ 6'h0A, base[1:0]}, 2'(c));
            access(base, 1, 1);
            snoop(base, 1);
          end

    summary();
  end
endmodule